// File: doc/BRIEF.md
# CAN Controller Module-Control Handshake

This block holds the module-control register of a CAN controller and runs the mode handshakes between the host clock domain and the protocol clock domain. The host can start a soft reset through a self-clearing bit. The request is carried into the protocol domain and returns as an acknowledge over a four-phase handshake. On the way, the block emits a one-cycle clear pulse in the protocol domain and a one-cycle clear pulse in the host domain. Other logic uses these pulses to clear the sequencer, the error counters, the error flags, the timer and the remaining host registers.

The host can also request freeze mode and disabled (low-power) mode. Each mode is confirmed by a read-only acknowledge bit. The protocol side enters a mode only once the bus-activity input shows idle. While either mode is held, the prescaler enable is driven low. The maximum-buffer field can only be written while the freeze acknowledge reads 1.

Register layout, host domain: bit 0 is the soft-reset bit, bit 1 the freeze request, bit 2 the disable request, bit 3 the freeze acknowledge (read-only) and bit 4 the low-power acknowledge (read-only). Bits 11:8 hold the maximum-buffer field. All other bits are reserved.

Top module: `can_modectl`

## Requirements
- R1: After reset the register reads 0x00000F00 (maximum-buffer field 0xF, every other bit 0), the prescaler enable is 1, and both clear pulses are 0.
- R2: A write with bit 0 set, made while no soft reset is in progress, starts a soft reset. Bit 0 then reads 1 until the request and the acknowledge have both returned to 0, and 0 after that. With two synchronizer stages this takes 11 host cycles after the write edge.
- R3: A soft reset produces exactly one protocol-domain clear pulse, one cycle long, when the request arrives there. It produces exactly one host-domain clear pulse, one cycle long, when the acknowledge arrives back.
- R4: The host clear sets the freeze request (bit 1) to 0 and the maximum-buffer field (bits 11:8) to 0xF, and leaves the disable request (bit 2) unchanged.
- R5: A write with bit 0 set while bit 0 reads 1 has no effect: no further clear pulse follows, and the reset ends at the same time.
- R6: The freeze acknowledge (bit 3) rises only after the freeze request has crossed to the protocol side and the bus-activity input is 0. The prescaler enable falls when freeze mode is entered.
- R7: When freeze is released, the prescaler enable returns to 1 first. The freeze acknowledge clears two host cycles later.
- R8: The low-power acknowledge (bit 4) rises only after the disable request has crossed over and the bus is idle. It clears after the request is withdrawn.
- R9: A write to bits 11:8 while the freeze acknowledge reads 0 is ignored, and the field keeps its value.
- R10: Reserved bits (31:12 and 7:5) always read 0, and writes to them and to bits 3 and 4 have no effect.
- R11: The soft-reset request stays asserted until its acknowledge has been seen in the host domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host register clock |
| rst_h_n | input | 1 | Host asynchronous active-low reset |
| clk_p | input | 1 | Protocol clock |
| rst_p_n | input | 1 | Protocol asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| host_clr_h | output | 1 | One-cycle clear for the host registers |
| bus_busy_p | input | 1 | Transmission or reception in progress (protocol domain) |
| core_clr_p | output | 1 | One-cycle clear for the sequencer, error counters, error flags and timer |
| presc_en_p | output | 1 | Prescaler enable, low while frozen or disabled |

## Verification
The bench builds the block with two synchronizer stages. It drives both domains from one clock, so every crossing has a fixed latency and each output has a single correct value in every cycle. This puts within reach the exact 11-cycle soft-reset window, the exact one-cycle placement of each clear pulse, and the two-cycle lag of the freeze acknowledge behind the prescaler enable. A behavioural model then checks all of these on every clock, including while the bus is held busy across a mode request and while a second reset request is made during a pending one.

// File: rtl/canmc_pkg.sv
package canmc_pkg;
  localparam int REG_W    = 32;
  localparam int B_SRST   = 0;
  localparam int B_FRZ    = 1;
  localparam int B_DIS    = 2;
  localparam int B_FACK   = 3;
  localparam int B_LACK   = 4;
  localparam int MB_LSB   = 8;
  localparam int MB_W     = 4;
  localparam logic [MB_W-1:0] MB_RST = 4'hF;
endpackage

// File: rtl/canmc_sync.sv
module canmc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/canmc_host.sv
module canmc_host
  import canmc_pkg::*;
(
  input  logic             clk_h,
  input  logic             rst_h_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             srst_ack_h,
  input  logic             frz_ack_h,
  input  logic             lp_ack_h,
  output logic             srst_req_h,
  output logic             frz_req_h,
  output logic             dis_req_h,
  output logic             host_clr_h,
  output logic [REG_W-1:0] rd_data
);
  logic            req_q, req_d;
  logic            frz_q, frz_d;
  logic            dis_q, dis_d;
  logic [MB_W-1:0] mb_q, mb_d;
  logic            clr_now, start_now, mb_wr_en;

  always_comb begin
    clr_now   = req_q & srst_ack_h;
    start_now = wr_en & wr_data[B_SRST] & ~req_q & ~srst_ack_h;
    mb_wr_en  = wr_en & frz_ack_h;
    req_d = req_q;
    frz_d = frz_q;
    dis_d = dis_q;
    mb_d  = mb_q;
    if (clr_now) begin
      req_d = 1'b0;
      frz_d = 1'b0;
      mb_d  = MB_RST;
    end else begin
      if (start_now) req_d = 1'b1;
      if (wr_en) begin
        frz_d = wr_data[B_FRZ];
        dis_d = wr_data[B_DIS];
      end
      if (mb_wr_en) mb_d = wr_data[MB_LSB +: MB_W];
    end
  end

  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) begin
      req_q <= 1'b0;
      frz_q <= 1'b0;
      dis_q <= 1'b0;
      mb_q  <= MB_RST;
    end else begin
      req_q <= req_d;
      frz_q <= frz_d;
      dis_q <= dis_d;
      mb_q  <= mb_d;
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[B_SRST]         = req_q | srst_ack_h;
    rd_data[B_FRZ]          = frz_q;
    rd_data[B_DIS]          = dis_q;
    rd_data[B_FACK]         = frz_ack_h;
    rd_data[B_LACK]         = lp_ack_h;
    rd_data[MB_LSB +: MB_W] = mb_q;
  end

  assign srst_req_h = req_q;
  assign frz_req_h  = frz_q;
  assign dis_req_h  = dis_q;
  assign host_clr_h = clr_now;

  // R11: request held until the returning acknowledge is seen
  assert_req_held_R11: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (req_q && !srst_ack_h) |=> req_q);
  // R9: buffer field frozen unless freeze ack or clear
  assert_mb_gated_R9: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (!frz_ack_h && !(req_q && srst_ack_h)) |=> $stable(mb_q));
  // R4: disable request survives the host clear
  assert_dis_kept_R4: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (req_q && srst_ack_h) |=> $stable(dis_q));
  // R5: no new request while the old acknowledge is still high
  assert_no_restart_R5: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    srst_ack_h |=> !$rose(req_q));
endmodule

// File: rtl/canmc_proto.sv
module canmc_proto (
  input  logic clk_p,
  input  logic rst_p_n,
  input  logic srst_req_p,
  input  logic frz_req_p,
  input  logic dis_req_p,
  input  logic bus_busy_p,
  output logic srst_ack_p,
  output logic frz_st_p,
  output logic lp_st_p,
  output logic core_clr_p,
  output logic presc_en_p
);
  logic ack_q, ack_d;
  logic fst_q, fst_d;
  logic lst_q, lst_d;

  always_comb begin
    ack_d = srst_req_p;
    fst_d = frz_req_p & (fst_q | ~bus_busy_p);
    lst_d = dis_req_p & (lst_q | ~bus_busy_p);
  end

  always_ff @(posedge clk_p or negedge rst_p_n) begin
    if (!rst_p_n) begin
      ack_q <= 1'b0;
      fst_q <= 1'b0;
      lst_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      fst_q <= fst_d;
      lst_q <= lst_d;
    end
  end

  assign srst_ack_p = ack_q;
  assign frz_st_p   = fst_q;
  assign lp_st_p    = lst_q;
  assign core_clr_p = srst_req_p & ~ack_q;
  assign presc_en_p = ~(fst_q | lst_q);

  // R3: protocol clear is a single-cycle pulse
  assert_clr_single_R3: assert property (@(posedge clk_p) disable iff (!rst_p_n)
    core_clr_p |=> !core_clr_p);
  // R6: freeze not entered while the bus is busy
  assert_frz_waits_R6: assert property (@(posedge clk_p) disable iff (!rst_p_n)
    (!fst_q && bus_busy_p) |=> !fst_q);
  // R8: disabled mode not entered while the bus is busy
  assert_lp_waits_R8: assert property (@(posedge clk_p) disable iff (!rst_p_n)
    (!lst_q && bus_busy_p) |=> !lst_q);
  // R7: prescaler runs again once freeze has been left and no disable holds
  assert_presc_back_R7: assert property (@(posedge clk_p) disable iff (!rst_p_n)
    (!frz_req_p && !dis_req_p) |=> presc_en_p);
endmodule

// File: rtl/can_modectl.sv
module can_modectl
  import canmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_h,
  input  logic             rst_h_n,
  input  logic             clk_p,
  input  logic             rst_p_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             host_clr_h,
  input  logic             bus_busy_p,
  output logic             core_clr_p,
  output logic             presc_en_p
);
  localparam int XW = 3;

  logic [XW-1:0] to_p_src, to_p_dst;
  logic [XW-1:0] to_h_src, to_h_dst;
  logic srst_req_h, frz_req_h, dis_req_h;
  logic srst_ack_p, frz_st_p, lp_st_p;

  canmc_host u_host (
    .clk_h      (clk_h),
    .rst_h_n    (rst_h_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .srst_ack_h (to_h_dst[0]),
    .frz_ack_h  (to_h_dst[1]),
    .lp_ack_h   (to_h_dst[2]),
    .srst_req_h (srst_req_h),
    .frz_req_h  (frz_req_h),
    .dis_req_h  (dis_req_h),
    .host_clr_h (host_clr_h),
    .rd_data    (rd_data)
  );

  assign to_p_src = {dis_req_h, frz_req_h, srst_req_h};

  canmc_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync_h2p (
    .clk   (clk_p),
    .rst_n (rst_p_n),
    .d     (to_p_src),
    .q     (to_p_dst)
  );

  canmc_proto u_proto (
    .clk_p      (clk_p),
    .rst_p_n    (rst_p_n),
    .srst_req_p (to_p_dst[0]),
    .frz_req_p  (to_p_dst[1]),
    .dis_req_p  (to_p_dst[2]),
    .bus_busy_p (bus_busy_p),
    .srst_ack_p (srst_ack_p),
    .frz_st_p   (frz_st_p),
    .lp_st_p    (lp_st_p),
    .core_clr_p (core_clr_p),
    .presc_en_p (presc_en_p)
  );

  assign to_h_src = {lp_st_p, frz_st_p, srst_ack_p};

  canmc_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync_p2h (
    .clk   (clk_h),
    .rst_n (rst_h_n),
    .d     (to_h_src),
    .q     (to_h_dst)
  );
endmodule

// File: tb/can_modectl_tb.sv
module can_modectl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [31:0] rd_data;
  logic        host_clr, core_clr, presc_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_modectl #(.SYNC_STAGES(2)) dut_i (
    .clk_h(clk), .rst_h_n(rst_n), .clk_p(clk), .rst_p_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .host_clr_h(host_clr), .bus_busy_p(busy),
    .core_clr_p(core_clr), .presc_en_p(presc_en)
  );

  // behavioural reference: delays expressed as value histories
  logic       m_req, m_frz, m_dis, m_fst, m_lst;
  logic [3:0] m_mb;
  logic [4:0] rh;
  logic [1:0] fh, dh, fsh, lsh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 0; m_frz <= 0; m_dis <= 0; m_fst <= 0; m_lst <= 0;
      m_mb <= 4'hF; rh <= '0; fh <= '0; dh <= '0; fsh <= '0; lsh <= '0;
    end else begin
      rh  <= {rh[3:0], m_req};
      fh  <= {fh[0], m_frz};
      dh  <= {dh[0], m_dis};
      fsh <= {fsh[0], m_fst};
      lsh <= {lsh[0], m_lst};
      m_fst <= fh[1] & (m_fst | !busy);
      m_lst <= dh[1] & (m_lst | !busy);
      if (m_req && rh[4]) begin
        m_req <= 0; m_frz <= 0; m_mb <= 4'hF;
      end else begin
        if (wr_en && wr_data[0] && !m_req && !rh[4]) m_req <= 1;
        if (wr_en) begin
          m_frz <= wr_data[1];
          m_dis <= wr_data[2];
          if (fsh[1]) m_mb <= wr_data[11:8];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2 srst bit", {31'b0, rd_data[0]}, {31'b0, m_req | rh[4]});
      chk("R4 frz/dis/mb", {rd_data[11:8], rd_data[2:1]}, {m_mb, m_dis, m_frz});
      chk("R6 frz ack", {31'b0, rd_data[3]}, {31'b0, fsh[1]});
      chk("R8 lp ack", {31'b0, rd_data[4]}, {31'b0, lsh[1]});
      chk("R10 reserved", rd_data & 32'hFFFF_F0E0, 32'h0);
      chk("R3 core clr", {31'b0, core_clr}, {31'b0, rh[1] & !rh[2]});
      chk("R3 host clr", {31'b0, host_clr}, {31'b0, m_req & rh[4]});
      chk("R7 presc en", {31'b0, presc_en}, {31'b0, !(m_fst | m_lst)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  int pulses;
  always @(negedge clk) if (core_clr) pulses++;

  initial begin
    pulses = 0;
    step(3);
    chk("R1 reset reg", rd_data, 32'h0000_0F00);
    chk("R1 reset presc", {31'b0, presc_en}, 32'h1);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", rd_data, 32'h0000_0F00);

    wr(32'h0000_0300);                 // R9: not frozen, ignored
    step(3);
    chk("R9 mb unchanged", {28'b0, rd_data[11:8]}, 32'hF);

    wr(32'hFFFF_F0F8);                 // R10: reserved and RO bits
    step(6);
    chk("R10 reserved ignored", rd_data, 32'h0000_0F00);

    busy = 1'b1;                       // R6: freeze held off by busy bus
    wr(32'h0000_0002);
    step(8);
    chk("R6 ack waits for idle", {31'b0, rd_data[3]}, 32'h0);
    busy = 1'b0;
    step(5);
    chk("R6 ack after idle", {31'b0, rd_data[3]}, 32'h1);
    chk("R6 presc stopped", {31'b0, presc_en}, 32'h0);
    wr(32'h0000_0502);                 // R9: frozen, accepted
    step(1);
    chk("R9 mb written", {28'b0, rd_data[11:8]}, 32'h5);

    wr(32'h0000_0506);                 // disable too
    step(6);
    chk("R8 lp ack idle bus", {31'b0, rd_data[4]}, 32'h1);

    pulses = 0;
    wr(32'h0000_0507);                 // R2: soft reset
    step(3);
    wr(32'h0000_0507);                 // R5: second request while pending
    step(3);
    chk("R2 pending", {31'b0, rd_data[0]}, 32'h1);
    step(10);
    chk("R2 completed", {31'b0, rd_data[0]}, 32'h0);
    chk("R5 single pulse", pulses, 32'd1);
    chk("R4 after clear", rd_data & 32'h0000_0F07, 32'h0000_0F04);

    wr(32'h0000_0000);                 // R7/R8: leave modes
    busy = 1'b1;
    step(8);
    chk("R7 presc back", {31'b0, presc_en}, 32'h1);
    chk("R8 lp ack cleared", {31'b0, rd_data[4]}, 32'h0);
    wr(32'h0000_0004);                 // R8: disable under busy bus
    step(8);
    chk("R8 lp waits", {31'b0, rd_data[4]}, 32'h0);
    busy = 1'b0;
    step(6);
    chk("R8 lp entered", {31'b0, rd_data[4]}, 32'h1);

    wr(32'h0000_0003);                 // reset with freeze requested
    step(14);
    chk("R4 frz cleared", {31'b0, rd_data[1]}, 32'h0);
    step(5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule